// File: doc/BRIEF.md
# Smart Card Character Transmitter

This block sends single characters over the one-wire, half-duplex I/O line of a contact smart card. A byte is accepted through a valid/ready handshake and sent as a start bit, eight data bits and a parity bit. Every bit lasts one elementary time unit (etu), which is a programmable number of clock cycles. The block only ever pulls the shared line low or releases it. The line is never driven high, so a receiving card can pull it low to signal an error.

After the parity bit the line is released for a guard period. Partway through that period the block reads the line. If the card is holding the line low at that moment, the same byte is sent again after a longer gap. The number of resends is limited by a programmable count. When the limit is used up the byte is dropped and a one-cycle flag marks the loss. Three controls select the character convention: bit order, inversion of the data and parity levels, and parity sense. With all three controls at 0 the block uses the direct convention: LSB first, no inversion, even parity.

The controls and the etu count must be held stable while a character is in flight, and the etu count must be at least 2.

Top module: `sc_char_tx`

## Requirements
- R1: While reset is asserted and afterwards until the first accepted byte, `in_ready` is 1, `line_pull_low` is 0 and `tx_dropped` is 0.
- R2: A byte is accepted on a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle on, `in_ready` is 0 and the start bit pulls the line low for slot 0.
- R3: Slots 1 to 8 carry the data bits. When `msb_first` is 0, slot k carries bit k-1 (LSB first). When `msb_first` is 1, slot k carries bit 8-k (MSB first).
- R4: The level on the line for a data slot is the data bit XOR `invert`. A level of 0 means `line_pull_low` is 1, and a level of 1 means the line is released.
- R5: Slot 9 carries the parity level: the XOR of all eight data bits, XOR `odd_parity`, XOR `invert`.
- R6: Each slot lasts exactly `etu_cycles` clock cycles, counted from the accept edge. The line is released in slots 10 and 11. When no error is seen, `in_ready` returns to 1 exactly 12 etu after the accept edge.
- R7: The line is sampled at the start of slot 11, which is 11 etu after the start edge and inside the card's error window from 10.5 to 11.5 etu. If the line is low at that point, the same byte is sent again, and its start bit begins 14 etu after the previous start edge.
- R8: At most `max_retries` resends are made. If the final attempt also sees an error, nothing more is sent. `in_ready` returns to 1 at 12 etu after that attempt's start, and `tx_dropped` is 1 for exactly that one cycle.
- R9: `in_valid` and `in_data` are ignored while `in_ready` is 0. A byte presented during a transfer neither changes the character being sent nor starts another one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| etu_cycles | input | ETU_W | Clock cycles per etu, at least 2 |
| msb_first | input | 1 | 1 = send data MSB first |
| invert | input | 1 | 1 = invert the data and parity levels |
| odd_parity | input | 1 | 1 = odd parity sense |
| max_retries | input | RETRY_W | Maximum number of automatic resends |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Block is idle and will take a byte |
| line_in | input | 1 | Level of the shared I/O line, read back |
| line_pull_low | output | 1 | 1 = pull the I/O line low, 0 = release it |
| tx_dropped | output | 1 | One-cycle pulse when a byte is dropped after its retries |

## Verification
The bench counts clock cycles from the accept edge. In cycle c after that edge the design is in slot c / etu, so each slot's level is read at the falling edge in the middle of the slot. The bench compares that level with the level it computes from the byte and the three controls.

The card model in the bench pulls the line low from 10.5 to 11 etu, which covers the design's sampling edge. When an error is injected, the bench expects the next start bit at 14 etu. `in_ready` and `tx_dropped` are checked at the falling edge right after 12 etu of the last attempt, and the bench checks that `tx_dropped` is back to 0 one cycle later.

The sweep covers all eight control combinations, six bytes and two etu lengths.

// File: rtl/sc_char_tx.sv
module sc_char_tx #(
  parameter int ETU_W   = 12,
  parameter int RETRY_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ETU_W-1:0]   etu_cycles,
  input  logic               msb_first,
  input  logic               invert,
  input  logic               odd_parity,
  input  logic [RETRY_W-1:0] max_retries,
  input  logic               in_valid,
  input  logic [7:0]         in_data,
  output logic               in_ready,
  input  logic               line_in,
  output logic               line_pull_low,
  output logic               tx_dropped
);
  localparam logic [3:0] PARITY_SLOT = 4'd9;
  localparam logic [3:0] SAMPLE_SLOT = 4'd11;
  localparam logic [3:0] RETX_SLOT   = 4'd13;

  logic               busy;
  logic [7:0]         byte_q;
  logic [ETU_W-1:0]   cnt;
  logic [3:0]         slot;
  logic [RETRY_W-1:0] tries;
  logic               err_q;
  logic               level;

  wire       etu_end = (cnt == etu_cycles - 1'b1);
  wire       accept  = in_valid && !busy;
  wire [3:0] sm1     = slot - 4'd1;
  wire [2:0] idx     = msb_first ? (3'd7 - sm1[2:0]) : sm1[2:0];
  wire       err_eff = (cnt == '0) ? !line_in : err_q;

  assign in_ready      = !busy;
  assign line_pull_low = busy && (slot <= PARITY_SLOT) && !level;

  always_comb begin
    if (slot == 4'd0)
      level = 1'b0;
    else if (slot < PARITY_SLOT)
      level = byte_q[idx] ^ invert;
    else
      level = (^byte_q) ^ odd_parity ^ invert;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      byte_q     <= '0;
      cnt        <= '0;
      slot       <= '0;
      tries      <= '0;
      err_q      <= 1'b0;
      tx_dropped <= 1'b0;
    end else begin
      tx_dropped <= 1'b0;
      if (!busy) begin
        if (accept) begin
          busy   <= 1'b1;
          byte_q <= in_data;
          cnt    <= '0;
          slot   <= '0;
          tries  <= '0;
          err_q  <= 1'b0;
        end
      end else begin
        if (slot == SAMPLE_SLOT && cnt == '0)
          err_q <= !line_in;
        if (!etu_end) begin
          cnt <= cnt + 1'b1;
        end else begin
          cnt <= '0;
          if (slot == SAMPLE_SLOT && (!err_eff || tries == max_retries)) begin
            busy       <= 1'b0;
            tx_dropped <= err_eff;
          end else if (slot == RETX_SLOT) begin
            slot  <= '0;
            tries <= tries + 1'b1;
            err_q <= 1'b0;
          end else begin
            slot <= slot + 4'd1;
          end
        end
      end
    end
  end

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> line_pull_low && !in_ready);

  assert_retx_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && slot == RETX_SLOT && etu_end |=> line_pull_low && !in_ready);

  assert_drop_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dropped |=> !tx_dropped);

  assert_drop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dropped |-> in_ready && !line_pull_low);

  assert_tries_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> tries <= max_retries);

  assert_byte_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> byte_q == $past(byte_q));
endmodule

// File: tb/tb_sc_char_tx.sv
module tb_sc_char_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] etu_cycles = 12'd4;
  logic        msb_first = 1'b0, invert = 1'b0, odd_parity = 1'b0;
  logic [2:0]  max_retries = 3'd0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready, line_pull_low, tx_dropped;
  logic        card_pull = 1'b0;
  wire         line_in = !(line_pull_low || card_pull);
  int checks = 0, failures = 0;

  always #2 clk = !clk;

  sc_char_tx dut (
    .clk(clk), .rst_n(rst_n), .etu_cycles(etu_cycles),
    .msb_first(msb_first), .invert(invert), .odd_parity(odd_parity),
    .max_retries(max_retries), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .line_in(line_in), .line_pull_low(line_pull_low),
    .tx_dropped(tx_dropped)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_level(input logic [7:0] b, input bit m, input bit i,
                                   input bit o, input int s);
    if (s == 0) return 1'b0;
    if (s <= 8) return b[m ? 8 - s : s - 1] ^ i;
    return (^b) ^ o ^ i;
  endfunction

  task automatic send(input logic [7:0] b, input bit m, input bit i, input bit o,
                      input int etu, input int maxr, input int nerr);
    int att = 0;
    bit done = 0;
    etu_cycles = 12'(etu);
    max_retries = 3'(maxr);
    msb_first = m; invert = i; odd_parity = o;
    in_data = b; in_valid = 1'b1;
    @(posedge clk);
    while (!done) begin
      bit inj = (att < nerr);
      bit retx = inj && (att < maxr);
      int total = retx ? 14 * etu : 12 * etu;
      for (int c = 0; c < total; c++) begin
        @(negedge clk);
        if (att == 0 && c == 0) in_valid = 1'b0;
        if (att == 0 && c == etu) begin in_valid = 1'b1; in_data = ~b; end
        if (att == 0 && c == 3 * etu) begin in_valid = 1'b0; in_data = b; end
        card_pull = inj && (c >= 10 * etu + etu / 2) && (c <= 11 * etu);
        if (c % etu == etu / 2) begin
          int s = c / etu;
          bit ep = (s <= 9) ? !exp_level(b, m, i, o, s) : 1'b0;
          if (s == 0)      chk(line_pull_low == ep, "R2 start bit", line_pull_low, ep);
          else if (s <= 8) chk(line_pull_low == ep, "R3 R4 data slot", line_pull_low, ep);
          else if (s == 9) chk(line_pull_low == ep, "R5 parity slot", line_pull_low, ep);
          else             chk(line_pull_low == ep, "R6 guard released", line_pull_low, ep);
          chk(in_ready == 1'b0, "R9 busy not ready", in_ready, 0);
        end
      end
      if (retx) att++;
      else done = 1;
    end
    @(negedge clk);
    card_pull = 1'b0;
    chk(in_ready == 1'b1, "R6 ready at 12 etu", in_ready, 1);
    chk(line_pull_low == 1'b0, "R6 line released", line_pull_low, 0);
    chk(tx_dropped == (nerr > maxr), "R8 drop flag", tx_dropped, int'(nerr > maxr));
    @(negedge clk);
    chk(tx_dropped == 1'b0, "R8 drop one cycle", tx_dropped, 0);
    chk(in_ready == 1'b1, "R9 no extra frame", in_ready, 1);
  endtask

  initial begin
    #800000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h01, 8'h80};
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1 reset ready", in_ready, 1);
    chk(line_pull_low == 1'b0, "R1 reset line", line_pull_low, 0);
    chk(tx_dropped == 1'b0, "R1 reset drop", tx_dropped, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 idle ready", in_ready, 1);
    for (int e = 0; e < 2; e++)
      for (int cv = 0; cv < 8; cv++)
        for (int p = 0; p < 6; p++)
          send(pats[p], cv[0], cv[1], cv[2], e ? 7 : 4, 2, 0);
    send(8'h5A, 1'b0, 1'b0, 1'b0, 4, 2, 1);
    send(8'hC3, 1'b1, 1'b1, 1'b0, 5, 3, 2);
    send(8'h96, 1'b0, 1'b0, 1'b1, 4, 2, 3);
    send(8'h2E, 1'b1, 1'b0, 1'b0, 6, 0, 1);
    send(8'h71, 1'b0, 1'b1, 1'b1, 4, 1, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule